// File: doc/BRIEF.md
# Polled SPI Register Access Engine

This block is the host side of a register link to a slow SPI slave. A client gives it one request at a time on a valid/ready interface: read or write, an address byte, and a 16-bit value to write. The engine asserts the active-low select and sends a command byte and then the address byte. On a write it also sends the two data bytes. It then sends filler bytes and checks each byte that comes back. A busy code (0x4E) means it keeps polling. An acknowledge code (0x41) ends the wait. On a read, the two bytes after the acknowledge carry the result, low byte first.

The slave handles every byte in firmware, so the engine puts an idle gap of host clocks between bytes. The length of that gap is set on an input pin. A second input limits how many busy replies the engine accepts before it gives up. When a transfer ends, the engine releases select and gives a one-cycle `done` pulse together with a status code and the read word.

Back-pressure on the request side works like this. `req_ready` is high only while the engine is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle of the `done` pulse. The result side has no back-pressure: `done` is a single-cycle pulse, and whatever logic receives it must capture it in that cycle.

Top module: `spi_reg_host`

## Requirements
- R1: After reset, `req_ready` is 1, `ssel_n` is 1, `sclk` is 0, `mosi` is 0 and `done` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low and `ssel_n` stays low from that point until the `done` pulse, and each request gives exactly one `done` pulse. `gap_cycles` and `poll_limit` are sampled when the request is taken.
- R3: The serial bus runs in mode 0. `sclk` is low when idle and each half period lasts DIV_HALF host clocks. `mosi` changes only while `sclk` is low, bits go out most significant first, `miso` is sampled on the rising edge, and every byte has exactly 8 rising edges.
- R4: The first byte is the command byte: 0x01 for a read and 0x81 for a write. The second byte is `req_addr`.
- R5: On a write, the command and address bytes are followed by `req_wdata[7:0]` and then `req_wdata[15:8]`.
- R6: After the request bytes, the engine sends filler bytes of 0x00. It keeps sending them as long as the slave replies 0x4E. The replies to the request bytes themselves are ignored.
- R7: On a read, the first byte whose reply is 0x41 is followed by exactly two more filler bytes. The reply to the first of these becomes `done_rdata[7:0]` and the reply to the second becomes `done_rdata[15:8]`.
- R8: On a write, a 0x41 reply ends the transfer with no further bytes. `done_status` is 0 (ok) and `done_rdata` is 0.
- R9: Within a transfer, `sclk` stays low for at least `gap_cycles` host clocks between the last falling edge of one byte and the first rising edge of the next.
- R10: Once max(`poll_limit`,1) consecutive 0x4E replies have arrived, the transfer ends with `done_status` = 1 (timeout) and `done_rdata` = 0, and no further byte is sent.
- R11: A poll reply that is neither 0x41 nor 0x4E ends the transfer at once with `done_status` = 2 (bad reply) and `done_rdata` = 0.
- R12: `done` lasts one cycle. In that cycle `ssel_n` is 1 and `req_ready` is 1, and `done_status` is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address byte |
| req_wdata | input | 16 | Value to write |
| gap_cycles | input | 16 | Minimum idle host clocks between bytes |
| poll_limit | input | 8 | Number of busy replies tolerated (0 is treated as 1) |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_rdata | output | 16 | Read result; 0 unless a read ends ok |
| done_status | output | 2 | 0 ok, 1 timeout, 2 bad reply |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ssel_n | output | 1 | Active-low slave select |

## Verification
The bench uses a slave model that answers a chosen number of busy codes before it sends the acknowledge or a stray code. This tests the edge case where the number of busy replies is exactly one below the poll limit, which must succeed, and the case where it equals the limit, which must time out. An off-by-one in the limit shows up as an extra poll byte or an early timeout. A poll limit of zero must behave like one, and a stray reply must stop the transfer rather than be taken as a busy code. On reads the bench checks the byte order, because swapped halves or sampling on the wrong edge corrupt the returned word. It also measures the idle low time of `sclk` between bytes, including with a gap of zero, because a gap counter that is loaded late or not at all lets bytes run together.

// File: rtl/spi_reg_host_pkg.sv
package spi_reg_host_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  localparam logic [BYTE_W-1:0] DEF_ACK    = 8'h41;
  localparam logic [BYTE_W-1:0] DEF_NACK   = 8'h4E;
  localparam logic [BYTE_W-1:0] DEF_CMD_RD = 8'h01;
  localparam logic [BYTE_W-1:0] DEF_CMD_WR = 8'h81;
  localparam logic [BYTE_W-1:0] DEF_DUMMY  = 8'h00;

  typedef enum logic [1:0] {
    XS_OK       = 2'd0,
    XS_TIMEOUT  = 2'd1,
    XS_BADREPLY = 2'd2
  } xfer_status_e;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_WLO, PH_WHI, PH_POLL, PH_RLO, PH_RHI
  } byte_phase_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_LOAD, SQ_SHIFT, SQ_GAP
  } seq_state_e;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_reg_host_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int DIV_CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DIV_CW-1:0] DIV_LAST = DIV_CW'(DIV_HALF - 1);
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(BYTE_W - 1);

  logic [DIV_CW-1:0] div_cnt;
  logic [BIT_CW-1:0] bit_cnt;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          tx_sh   <= tx_byte;
          div_cnt <= '0;
          bit_cnt <= '0;
          sclk    <= 1'b0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[BYTE_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == BIT_LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign mosi    = busy & tx_sh[BYTE_W-1];
  assign rx_byte = rx_sh;
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/spi_reg_seq.sv
module spi_reg_seq
  import spi_reg_host_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int GAP_W  = 16,
  parameter int POLL_W = 8,
  parameter logic [BYTE_W-1:0] CODE_ACK  = DEF_ACK,
  parameter logic [BYTE_W-1:0] CODE_NACK = DEF_NACK,
  parameter logic [BYTE_W-1:0] CMD_RD    = DEF_CMD_RD,
  parameter logic [BYTE_W-1:0] CMD_WR    = DEF_CMD_WR,
  parameter logic [BYTE_W-1:0] FILLER    = DEF_DUMMY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [GAP_W-1:0]  gap_cycles,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              done,
  output logic [WORD_W-1:0] done_rdata,
  output logic [1:0]        done_status,
  output logic              ssel_n,
  output logic              byte_start,
  output logic [BYTE_W-1:0] byte_tx,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_rx,
  output logic              gap_load,
  output logic [GAP_W-1:0]  gap_val,
  input  logic              gap_expired
);
  localparam int LIM_W = POLL_W + 1;

  seq_state_e   state_q;
  byte_phase_e  phase_q;
  xfer_status_e stat_q;
  logic              wr_q, fin_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;
  logic [GAP_W-1:0]  gap_q;
  logic [POLL_W-1:0] limit_q, nack_q;
  logic [LIM_W-1:0]  eff_limit, nack_next;

  assign eff_limit = (limit_q == '0) ? LIM_W'(1) : {1'b0, limit_q};
  assign nack_next = {1'b0, nack_q} + LIM_W'(1);

  assign req_ready  = (state_q == SQ_IDLE);
  assign byte_start = (state_q == SQ_LOAD);
  assign gap_load   = (state_q == SQ_SHIFT) && byte_done;
  assign gap_val    = gap_q;

  always_comb begin
    unique case (phase_q)
      PH_CMD:  byte_tx = wr_q ? CMD_WR : CMD_RD;
      PH_ADDR: byte_tx = BYTE_W'(addr_q);
      PH_WLO:  byte_tx = wdata_q[BYTE_W-1:0];
      PH_WHI:  byte_tx = wdata_q[WORD_W-1:BYTE_W];
      default: byte_tx = FILLER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      phase_q     <= PH_CMD;
      stat_q      <= XS_OK;
      wr_q        <= 1'b0;
      fin_q       <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      gap_q       <= '0;
      limit_q     <= '0;
      nack_q      <= '0;
      ssel_n      <= 1'b1;
      done        <= 1'b0;
      done_rdata  <= '0;
      done_status <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (req_valid) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            gap_q   <= gap_cycles;
            limit_q <= poll_limit;
            nack_q  <= '0;
            rdata_q <= '0;
            fin_q   <= 1'b0;
            stat_q  <= XS_OK;
            phase_q <= PH_CMD;
            ssel_n  <= 1'b0;
            state_q <= SQ_LOAD;
          end
        end
        SQ_LOAD: state_q <= SQ_SHIFT;
        SQ_SHIFT: begin
          if (byte_done) begin
            state_q <= SQ_GAP;
            unique case (phase_q)
              PH_CMD:  phase_q <= PH_ADDR;
              PH_ADDR: phase_q <= wr_q ? PH_WLO : PH_POLL;
              PH_WLO:  phase_q <= PH_WHI;
              PH_WHI:  phase_q <= PH_POLL;
              PH_POLL: begin
                if (byte_rx == CODE_ACK) begin
                  if (wr_q) begin
                    fin_q  <= 1'b1;
                    stat_q <= XS_OK;
                  end else begin
                    phase_q <= PH_RLO;
                  end
                end else if (byte_rx == CODE_NACK) begin
                  if (nack_next >= eff_limit) begin
                    fin_q  <= 1'b1;
                    stat_q <= XS_TIMEOUT;
                  end else begin
                    nack_q <= nack_q + 1'b1;
                  end
                end else begin
                  fin_q  <= 1'b1;
                  stat_q <= XS_BADREPLY;
                end
              end
              PH_RLO: begin
                rdata_q[BYTE_W-1:0] <= byte_rx;
                phase_q             <= PH_RHI;
              end
              default: begin
                rdata_q[WORD_W-1:BYTE_W] <= byte_rx;
                fin_q                    <= 1'b1;
                stat_q                   <= XS_OK;
              end
            endcase
          end
        end
        default: begin
          if (gap_expired) begin
            if (fin_q) begin
              state_q     <= SQ_IDLE;
              ssel_n      <= 1'b1;
              done        <= 1'b1;
              done_status <= stat_q;
              done_rdata  <= rdata_q;
            end else begin
              state_q <= SQ_LOAD;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_host.sv
module spi_reg_host
  import spi_reg_host_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int GAP_W    = 16,
  parameter int POLL_W   = 8,
  parameter int DIV_HALF = 2,
  parameter logic [7:0] CODE_ACK  = DEF_ACK,
  parameter logic [7:0] CODE_NACK = DEF_NACK,
  parameter logic [7:0] CMD_RD    = DEF_CMD_RD,
  parameter logic [7:0] CMD_WR    = DEF_CMD_WR,
  parameter logic [7:0] FILLER    = DEF_DUMMY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [GAP_W-1:0]  gap_cycles,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              done,
  output logic [15:0]       done_rdata,
  output logic [1:0]        done_status,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ssel_n
);
  logic              byte_start, byte_busy, byte_done, gap_load, gap_expired;
  logic [BYTE_W-1:0] byte_tx, byte_rx;
  logic [GAP_W-1:0]  gap_val;

  spi_reg_seq #(
    .ADDR_W(ADDR_W), .GAP_W(GAP_W), .POLL_W(POLL_W),
    .CODE_ACK(CODE_ACK), .CODE_NACK(CODE_NACK),
    .CMD_RD(CMD_RD), .CMD_WR(CMD_WR), .FILLER(FILLER)
  ) i_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .gap_cycles(gap_cycles), .poll_limit(poll_limit),
    .done(done), .done_rdata(done_rdata), .done_status(done_status),
    .ssel_n(ssel_n),
    .byte_start(byte_start), .byte_tx(byte_tx),
    .byte_done(byte_done), .byte_rx(byte_rx),
    .gap_load(gap_load), .gap_val(gap_val), .gap_expired(gap_expired)
  );

  spi_byte_shifter #(.DIV_HALF(DIV_HALF)) i_shift (
    .clk(clk), .rst_n(rst_n),
    .start(byte_start), .tx_byte(byte_tx),
    .busy(byte_busy), .done(byte_done), .rx_byte(byte_rx),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  spi_gap_timer #(.CNT_W(GAP_W)) i_gap (
    .clk(clk), .rst_n(rst_n),
    .load(gap_load), .load_val(gap_val), .expired(gap_expired)
  );
endmodule

// File: rtl/spi_reg_host_chk.sv
module spi_reg_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic [1:0] done_status,
  input logic       ssel_n,
  input logic       sclk,
  input logic       mosi
);
  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ssel_n |-> !req_ready);
  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !ssel_n));
  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ssel_n |-> !sclk);
  // R3
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ssel_n && req_ready && done_status != 2'd3));
endmodule

bind spi_reg_host spi_reg_host_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .done_status(done_status), .ssel_n(ssel_n),
  .sclk(sclk), .mosi(mosi)
);

// File: tb/test_spi_reg_host.sv
module test_spi_reg_host;
  localparam logic [7:0] ACK = 8'h41, NACK = 8'h4E;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0, poll_limit = '0;
  logic [15:0] req_wdata = '0, gap_cycles = '0;
  logic req_ready, done, sclk, mosi, miso, ssel_n;
  logic [15:0] done_rdata;
  logic [1:0]  done_status;

  always #10 clk = ~clk;

  spi_reg_host i_spi_reg_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .gap_cycles(gap_cycles), .poll_limit(poll_limit), .done(done),
    .done_rdata(done_rdata), .done_status(done_status), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ssel_n(ssel_n)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model configuration
  bit         s_wr;
  int         s_nacks;
  logic [7:0] s_final;
  logic [15:0] s_data;
  logic [7:0] s_tx, s_rx;
  int         s_bit, s_idx;
  logic [7:0] mosi_log [0:63];

  function automatic logic [7:0] reply(int idx);
    int p0, j;
    p0 = s_wr ? 4 : 2;
    if (idx < p0) return 8'hC1 + 8'(idx);
    j = idx - p0;
    if (j < s_nacks) return NACK;
    if (j == s_nacks) return s_final;
    if (j == s_nacks + 1) return s_data[7:0];
    if (j == s_nacks + 2) return s_data[15:8];
    return 8'hEE;
  endfunction

  assign miso = s_tx[7];

  always @(negedge ssel_n) begin
    s_idx = 0; s_bit = 0; s_tx = reply(0);
  end
  always @(posedge sclk) if (ssel_n === 1'b0) begin
    s_rx = {s_rx[6:0], mosi}; s_bit++;
  end
  always @(negedge sclk) if (ssel_n === 1'b0) begin
    if (s_bit == 8) begin
      if (s_idx < 64) mosi_log[s_idx] = s_rx;
      s_idx++; s_bit = 0; s_tx = reply(s_idx);
    end else s_tx = s_tx << 1;
  end

  // monitor
  int  rise_cnt, low_run, min_gap, done_cnt;
  bit  ready_bad, prev_sclk;
  logic [1:0]  cap_status;
  logic [15:0] cap_rdata;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ssel_n === 1'b0) begin
        if (req_ready) ready_bad = 1;
        if (sclk && !prev_sclk) begin
          if (rise_cnt > 0 && rise_cnt % 8 == 0 && low_run < min_gap) min_gap = low_run;
          rise_cnt++;
          low_run = 0;
        end else if (!sclk) low_run++;
      end
      if (done) begin
        done_cnt++; cap_status = done_status; cap_rdata = done_rdata;
      end
      prev_sclk = sclk;
    end
  end

  task automatic run_txn(bit wr, logic [7:0] addr, logic [15:0] wd, int nacks,
                         logic [7:0] fin, int gap, int lim, logic [15:0] data);
    int p0, L, exp_bytes, exp_stat, cyc;
    logic [15:0] exp_rd;
    bit mosi_ok;
    s_wr = wr; s_nacks = nacks; s_final = fin; s_data = data;
    rise_cnt = 0; low_run = 0; min_gap = 1 << 30; done_cnt = 0; ready_bad = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
    gap_cycles = 16'(gap); poll_limit = 8'(lim);
    @(negedge clk);
    req_valid = 0;
    gap_cycles = 16'hFFFF; poll_limit = 8'hFF; // must have been latched (R2)
    cyc = 0;
    while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
    repeat (3) @(negedge clk);
    // expected outcome from the requirements
    p0 = wr ? 4 : 2;
    L = (lim == 0) ? 1 : lim;
    exp_rd = 16'h0;
    if (nacks >= L) begin exp_stat = 1; exp_bytes = p0 + L; end
    else if (fin == ACK) begin
      exp_stat = 0; exp_bytes = p0 + nacks + 1 + (wr ? 0 : 2);
      if (!wr) exp_rd = data;
    end else begin exp_stat = 2; exp_bytes = p0 + nacks + 1; end
    chk(done_cnt == 1, "R12", "done pulses", done_cnt, 1);
    chk(!ready_bad, "R2", "ready low while busy", ready_bad, 0);
    chk(cap_status == 2'(exp_stat),
        exp_stat == 1 ? "R10" : (exp_stat == 2 ? "R11" : (wr ? "R8" : "R7")),
        "status", cap_status, exp_stat);
    chk(cap_rdata == exp_rd, wr ? "R8" : "R7", "rdata", cap_rdata, exp_rd);
    chk(rise_cnt == exp_bytes * 8, "R6", "sclk rising edges", rise_cnt, exp_bytes * 8);
    chk(min_gap >= gap, "R9", "min idle gap", min_gap, gap);
    mosi_ok = (mosi_log[0] == (wr ? 8'h81 : 8'h01));
    chk(mosi_ok, "R4", "command byte", mosi_log[0], wr ? 8'h81 : 8'h01);
    chk(mosi_log[1] == addr, "R4", "address byte", mosi_log[1], addr);
    if (wr) begin
      chk(mosi_log[2] == wd[7:0], "R5", "wdata low", mosi_log[2], wd[7:0]);
      chk(mosi_log[3] == wd[15:8], "R5", "wdata high", mosi_log[3], wd[15:8]);
    end
    mosi_ok = 1;
    for (int i = p0; i < exp_bytes && i < 64; i++) if (mosi_log[i] != 8'h00) mosi_ok = 0;
    chk(mosi_ok, "R6", "filler bytes zero", mosi_ok, 1);
    chk(req_ready && ssel_n && !sclk, "R12", "idle after done",
        {req_ready, ssel_n, sclk}, 3'b110);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1 && ssel_n == 1 && sclk == 0 && mosi == 0 && done == 0,
        "R1", "reset outputs", {req_ready, ssel_n, sclk, mosi, done}, 5'b11000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1 && ssel_n == 1, "R1", "idle after reset", {req_ready, ssel_n}, 2'b11);
    // R3 quick framing: a mode-0 byte of DIV_HALF=2 takes 32 clocks; covered by edge counts
    run_txn(0, 8'h12, 16'h0, 0, ACK, 5, 4, 16'hBEEF);   // R7 read, immediate ACK
    run_txn(0, 8'h34, 16'h0, 3, ACK, 10, 8, 16'hA55A);  // R6 R7 polling
    run_txn(1, 8'h56, 16'hC3D2, 2, ACK, 7, 5, 16'h0);   // R5 R8 write
    run_txn(0, 8'h78, 16'h0, 5, ACK, 3, 3, 16'h1111);   // R10 timeout
    run_txn(0, 8'h9A, 16'h0, 1, ACK, 3, 0, 16'h2222);   // R10 limit zero acts as one
    run_txn(0, 8'hBC, 16'h0, 3, ACK, 2, 4, 16'h8001);   // R10 boundary: limit-1 busy ok
    run_txn(1, 8'hBD, 16'h7777, 4, ACK, 2, 4, 16'h0);   // R10 boundary: equal -> timeout
    run_txn(0, 8'hDE, 16'h0, 2, 8'h55, 4, 6, 16'h3333); // R11 bad reply read
    run_txn(1, 8'hEF, 16'h0102, 0, 8'h00, 4, 6, 16'h0); // R11 bad reply write
    run_txn(0, 8'h01, 16'h0, 1, ACK, 0, 2, 16'h00FF);   // R9 zero gap
    for (int n = 0; n < 30; n++) begin
      logic [7:0] f;
      f = ($urandom % 6 == 0) ? 8'h5A : ACK;
      run_txn(1'($urandom % 2), 8'($urandom), 16'($urandom), int'($urandom % 9), f,
              int'($urandom % 40), int'($urandom % 8), 16'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule